// File: doc/BRIEF.md
# Encoder and Hall Input Conditioner

This block cleans up the raw, asynchronous feedback lines of a motor position sensor before any decoder sees them. It takes six lines: the two quadrature channels and the index channel of an incremental encoder, and three hall-sensor lines. Each line is brought into the 100 MHz logic clock through its own two-flop synchronizer. A per-line glitch filter then rejects any level that does not last for a programmable number of clock cycles.

One 32-bit threshold, counted in logic-clock cycles, sets the rejected width for all six lines. At 100 MHz the rejected time is the count times 10 ns. The filtered encoder lines feed the quadrature decoder and the index capture logic. The filtered hall lines are presented as one 3-bit vector that the commutation logic can read directly. Polarity selection and decoding belong to the downstream blocks.

Each filter keeps a run counter. The counter is zero while the synchronized line equals the filtered output, and it advances on every cycle that the two disagree. The output takes the new level on the cycle the run reaches the threshold. A disagreement that ends early sends the counter back to zero.

Top module: `enc_input_conditioner`

## Requirements
- R1: A synchronous reset drives every filtered output to 0 and clears the filter state. The outputs stay 0 until a line has been high long enough to pass.
- R2: Each line passes through two synchronizer flops before its filter. With a threshold of 1, a raw change seen at a rising edge reaches the filtered output after the third rising edge, counting that edge as the first.
- R3: Threshold values 0 and 1 behave identically. Both add no cycles beyond the synchronizer and the output register, so even a one-cycle level passes.
- R4: For a threshold T of 1 or more, a synchronized level held for at least T consecutive cycles passes. The output changes on the T-th rising edge after the synchronized line first differs from it, which is 2+T edges after the raw change is first sampled.
- R5: A synchronized level that lasts fewer than T cycles is ignored, and the filtered output keeps its previous value.
- R6: If the synchronized line returns to the output level before the threshold is reached, the run count restarts. Two short pulses separated by a gap never add up.
- R7: The six lines are filtered independently under the shared threshold. A short pulse on one line does not affect the result on another.
- R8: Bit i of `hall_flt` is the filtered version of bit i of `hall_raw`, so the vector reads {hall 2, hall 1, hall 0}.
- R9: Falling levels are filtered exactly like rising ones. A short low glitch on a line whose output is high is ignored, and a long one drives the output back to 0.
- R10: The filtered output never changes on a cycle in which the synchronized line matched it on the previous edge. When the output does change, it takes the value of the synchronized line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz logic clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_raw | input | 1 | Raw encoder channel A, asynchronous |
| enc_b_raw | input | 1 | Raw encoder channel B, asynchronous |
| enc_idx_raw | input | 1 | Raw encoder index channel, asynchronous |
| hall_raw | input | 3 | Raw hall-sensor lines, asynchronous |
| min_width | input | 32 | Rejected pulse width in clock cycles; 0 and 1 disable filtering |
| enc_a_flt | output | 1 | Synchronized and filtered channel A |
| enc_b_flt | output | 1 | Synchronized and filtered channel B |
| enc_idx_flt | output | 1 | Synchronized and filtered index channel |
| hall_flt | output | 3 | Synchronized and filtered hall vector {hall 2, hall 1, hall 0} |

## Verification
The bench builds the block with its default parameters: three hall lines and a 32-bit threshold. The only thing it varies is the run-time threshold, which it sets between 0 and 20. That range covers the bypass values 0 and 1, a pulse exactly one cycle short of the threshold and one exactly equal to it, and patterns that drive all six lines at once. The timing of every passing pulse is checked edge by edge against the 2+T latency. Directed runs cover an interrupted pulse, a mixed-width pulse across lines, a low glitch on a high output, and reset while the outputs are high. The full 32-bit threshold range is not reached, because the run counter compares with one extra bit and needs no wrap test.

// File: rtl/inpcond_pkg.sv
package inpcond_pkg;
  // Line positions inside the internal line vector
  localparam int unsigned LINE_A    = 0;
  localparam int unsigned LINE_B    = 1;
  localparam int unsigned LINE_IDX  = 2;
  localparam int unsigned HALL_BASE = 3;
  localparam int unsigned ENC_LINES = 3;

  function automatic int unsigned total_lines(input int unsigned hall_lines);
    return ENC_LINES + hall_lines;
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end

  // R2
  two_stage_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/pulse_width_filter.sv
module pulse_width_filter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [CNT_W-1:0] min_width,
  output logic             dout
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] run_cnt;
  logic [EXT_W-1:0] run_next;
  logic             run_done;

  // One extra bit: a threshold of 0 or 1 is met on the first differing cycle
  assign run_next = {1'b0, run_cnt} + EXT_W'(1);
  assign run_done = (run_next >= {1'b0, min_width});

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      dout    <= 1'b0;
    end else if (din == dout) begin
      run_cnt <= '0;
    end else if (run_done) begin
      dout    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_next[CNT_W-1:0];
    end
  end

  // R10
  hold_when_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(din) == $past(dout))) |-> $stable(dout));

  // R10
  change_toward_input_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (dout != $past(dout))) |-> (dout == $past(din)));

  // R3
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(min_width) <= CNT_W'(1))) |-> (dout == $past(din)));
endmodule

// File: rtl/enc_input_conditioner.sv
module enc_input_conditioner
  import inpcond_pkg::*;
#(
  parameter int unsigned HALL_LINES = 3,
  parameter int unsigned THR_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enc_a_raw,
  input  logic                  enc_b_raw,
  input  logic                  enc_idx_raw,
  input  logic [HALL_LINES-1:0] hall_raw,
  input  logic [THR_W-1:0]      min_width,
  output logic                  enc_a_flt,
  output logic                  enc_b_flt,
  output logic                  enc_idx_flt,
  output logic [HALL_LINES-1:0] hall_flt
);
  localparam int unsigned NUM_LINES = total_lines(HALL_LINES);

  logic [NUM_LINES-1:0] raw_vec;
  logic [NUM_LINES-1:0] sync_vec;
  logic [NUM_LINES-1:0] flt_vec;

  assign raw_vec = {hall_raw, enc_idx_raw, enc_b_raw, enc_a_raw};

  sync_2ff #(.WIDTH(NUM_LINES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_vec),
    .sync_out (sync_vec)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    pulse_width_filter #(.CNT_W(THR_W)) filt_i (
      .clk       (clk),
      .rst       (rst),
      .din       (sync_vec[g]),
      .min_width (min_width),
      .dout      (flt_vec[g])
    );
  end

  assign enc_a_flt   = flt_vec[LINE_A];
  assign enc_b_flt   = flt_vec[LINE_B];
  assign enc_idx_flt = flt_vec[LINE_IDX];
  assign hall_flt    = flt_vec[HALL_BASE +: HALL_LINES];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (flt_vec == '0));
endmodule

// File: tb/enc_input_conditioner_tb_top.sv
module enc_input_conditioner_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a_raw = 1'b0, b_raw = 1'b0, z_raw = 1'b0;
  logic [2:0] h_raw = 3'b000;
  logic [31:0] thr = 32'd1;
  logic       a_flt, b_flt, z_flt;
  logic [2:0] h_flt;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  enc_input_conditioner dut_i (
    .clk(clk), .rst(rst), .enc_a_raw(a_raw), .enc_b_raw(b_raw),
    .enc_idx_raw(z_raw), .hall_raw(h_raw), .min_width(thr),
    .enc_a_flt(a_flt), .enc_b_flt(b_flt), .enc_idx_flt(z_flt), .hall_flt(h_flt)
  );

  // Line vector for the bench: {hall2, hall1, hall0, idx, b, a}
  function automatic logic [5:0] outs();
    return {h_flt, z_flt, b_flt, a_flt};
  endfunction

  task automatic drive(input logic [5:0] v);
    {h_raw, z_raw, b_raw, a_raw} = v;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // {threshold[31:0], pattern[5:0], width[15:0], passes[0]}
  localparam int NV = 10;
  localparam logic [54:0] VECS [NV] = '{
    {32'd0,  6'b000001, 16'd1,  1'b1},   // R3
    {32'd1,  6'b000010, 16'd1,  1'b1},   // R3
    {32'd3,  6'b000100, 16'd2,  1'b0},   // R5
    {32'd3,  6'b001000, 16'd3,  1'b1},   // R4
    {32'd5,  6'b010000, 16'd4,  1'b0},   // R5
    {32'd5,  6'b100000, 16'd5,  1'b1},   // R4 R8
    {32'd2,  6'b111111, 16'd2,  1'b1},   // R4 R7
    {32'd8,  6'b101010, 16'd12, 1'b1},   // R4 R9
    {32'd8,  6'b010101, 16'd7,  1'b0},   // R5
    {32'd20, 6'b000111, 16'd20, 1'b1}    // R4
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    step(3);
    check("R1 reset outputs", 32'(outs()), 32'd0);
    rst = 1'b0;
    step(2);
    check("R1 after release", 32'(outs()), 32'd0);

    // Table walk: the first edge of change must be 2+max(T,1), otherwise never
    for (int v = 0; v < NV; v++) begin
      logic [31:0] t;
      logic [5:0]  pat;
      int          w, teff, first, limit;
      logic [5:0]  seen;
      bit          pass;
      {t, pat, w, pass} = {VECS[v][54:23], VECS[v][22:17], 32'(VECS[v][16:1]), VECS[v][0]};
      thr   = t;
      teff  = (t <= 1) ? 1 : int'(t);
      first = -1;
      seen  = '0;
      limit = w + teff + 6;
      drive(pat);
      for (int c = 1; c <= limit; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (c == w) drive(6'b0);
        if (first < 0 && outs() != 6'b0) begin
          first = c;
          seen  = outs();
        end
      end
      if (pass) begin
        check($sformatf("R4 vec%0d first edge", v), 32'(first), 32'(2 + teff));
        check($sformatf("R8 vec%0d lines", v), 32'(seen), 32'(pat));
      end else begin
        check($sformatf("R5 vec%0d rejected", v), 32'(first), 32'hFFFF_FFFF);
      end
      check($sformatf("R9 vec%0d back low", v), 32'(outs()), 32'd0);
    end

    // R2: threshold 1, edge-by-edge latency on channel A
    thr = 32'd1;
    drive(6'b000001);
    step(2);
    check("R2 not yet after 2 edges", 32'(a_flt), 32'd0);
    step(1);
    check("R2 after 3 edges", 32'(a_flt), 32'd1);
    drive(6'b0);
    step(4);

    // R6: 3 high, 1 low, 3 high under T=4 is rejected
    thr = 32'd4;
    drive(6'b000100); step(3);
    drive(6'b0);      step(1);
    drive(6'b000100); step(3);
    drive(6'b0);      step(8);
    check("R6 interrupted pulse", 32'(z_flt), 32'd0);
    drive(6'b000100); step(6);
    check("R6 full pulse passes", 32'(z_flt), 32'd1);

    // R9: index output is high; a 2-cycle low glitch must be ignored
    drive(6'b0);      step(2);
    drive(6'b000100); step(8);
    check("R9 low glitch ignored", 32'(z_flt), 32'd1);
    drive(6'b0);      step(7);
    check("R9 long low passes", 32'(z_flt), 32'd0);

    // R7: A held 5 cycles, B only 2, T=3: only A passes
    thr = 32'd3;
    drive(6'b000011); step(2);
    drive(6'b000001); step(3);
    check("R7 A passed", 32'(a_flt), 32'd1);
    check("R7 B rejected", 32'(b_flt), 32'd0);
    step(3);
    check("R7 B still low", 32'(b_flt), 32'd0);

    // R8: single hall line 1 alone
    drive(6'b010000); step(6);
    check("R8 hall bit1", 32'(h_flt), 32'd2);

    // R1: reset while outputs are high
    rst = 1'b1;
    step(1);
    check("R1 mid-run reset", 32'(outs()), 32'd0);
    step(2);
    rst = 1'b0;
    drive(6'b0);
    step(2);
    check("R1 stays low", 32'(outs()), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule